// File: doc/BRIEF.md
# Double-Buffered Block Load Scheduler

This block runs on the controller side of a mirror-array load path. Each block arrives as a control word that names an operation, then optional block data, then a load request that closes the block. The scheduler keeps a descriptor for each of two block buffers. One buffer fills from the receive side while the other drains to the array writer. Loads start strictly in the order the blocks were closed.

A load request that arrives while a load is running is held as a pending block. That block starts as soon as the running load ends. Clear and set operations carry no data but use the same request path and the same busy interval. Excess requests and excess control words are rejected, and each kind of rejection raises its own sticky flag.

Top module: `blk_load_sched`

## Requirements
- R1: After reset, `busy_n_o` is high, `wr_start_o` is low and both overrun flags are low.
- R2: A closed block whose start conditions hold is issued two clock edges after its load request is sampled. `wr_start_o` is high for exactly one cycle, `wr_op_o` carries the block's operation code, and `busy_n_o` goes low in the same cycle.
- R3: A data-load operation keeps `busy_n_o` low until `wr_done_i` is sampled high, and `busy_n_o` is high in the cycle after that edge. `wr_done_i` has no effect while idle or during a clear or set.
- R4: A clear or set operation holds `busy_n_o` low for exactly `CLR_CYCLES` cycles and does not need a data-complete indication.
- R5: A load request sampled while busy is stored. Its block starts on the second edge after the running load ends, so `busy_n_o` is high for exactly one cycle in between.
- R6: A data-load block whose request arrives before `data_done_i` is held back. It starts on the edge after `data_done_i` is sampled.
- R7: Consecutive loads drain alternate buffers. `wr_buf_o` is 0 for the first load after reset, then 1, 0, and so on.
- R8: A load request sampled when no block is open (for example while one block drains and another is pending) is discarded. It starts no load and sets the sticky `req_ovr_o`.
- R9: A control word sampled while the receive buffer still holds an unloaded block is dropped and sets the sticky `buf_ovr_o`. Once that buffer frees, the next control word is accepted.
- R10: Operation codes are 2'b00 data load, 2'b01 clear and 2'b10 set. Code 2'b11 is a fill that is timed like clear and set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cw_valid_i | input | 1 | Control word strobe, opens a block |
| cw_op_i | input | 2 | Operation code of the control word |
| data_done_i | input | 1 | Block data complete for the newest opened block |
| load_req_i | input | 1 | Load request, closes the open block |
| wr_done_i | input | 1 | Array writer finished a data load |
| wr_start_o | output | 1 | One-cycle start command to the array writer |
| wr_op_o | output | 2 | Operation of the running load |
| wr_buf_o | output | 1 | Buffer being drained |
| busy_n_o | output | 1 | Low while a load runs |
| req_ovr_o | output | 1 | Sticky: request discarded |
| buf_ovr_o | output | 1 | Sticky: control word dropped |

## Verification
On every cycle, the assertions check that start commands are single pulses issued only from idle, and that busy returns high only after a writer done or a timed operation. They also check that each buffer descriptor moves only through empty, open, ready and back to empty, and that both overrun flags stay set once raised. The bench scenarios are needed for the rest. These are the exact busy-low length of timed operations, the deferral of a data load until its data completes, the one-cycle gap before a pending block runs, buffer alternation across a sequence of loads, and recovery after a dropped control word.

// File: rtl/blk_sched_pkg.sv
package blk_sched_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_SET   = 2'b10,
    OP_FILL  = 2'b11
  } blk_op_e;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'b00,
    SLOT_OPEN  = 2'b01,
    SLOT_READY = 2'b10
  } slot_st_e;
endpackage

// File: rtl/blk_slot.sv
module blk_slot
  import blk_sched_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     open_i,
  input  blk_op_e  op_i,
  input  logic     close_i,
  input  logic     data_i,
  input  logic     free_i,
  output slot_st_e state_o,
  output blk_op_e  op_o,
  output logic     dok_o
);
  slot_st_e st_q;
  blk_op_e  op_q;
  logic     dok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SLOT_EMPTY;
      op_q  <= OP_LOAD;
      dok_q <= 1'b0;
    end else begin
      if (data_i) dok_q <= 1'b1;
      if (open_i) begin
        st_q  <= SLOT_OPEN;
        op_q  <= op_i;
        dok_q <= 1'b0;
      end
      if (close_i) st_q <= SLOT_READY;
      if (free_i) begin
        st_q  <= SLOT_EMPTY;
        dok_q <= 1'b0;
      end
    end
  end

  assign state_o = st_q;
  assign op_o    = op_q;
  assign dok_o   = dok_q;

  // R9
  open_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |-> st_q == SLOT_EMPTY);
  // R8
  close_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |-> st_q == SLOT_OPEN);
  // R7
  free_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> st_q == SLOT_READY);
endmodule

// File: rtl/blk_drain_seq.sv
module blk_drain_seq
  import blk_sched_pkg::*;
#(
  parameter int CLR_CYCLES = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    head_ready_i,
  input  blk_op_e head_op_i,
  input  logic    head_dok_i,
  input  logic    wr_done_i,
  output logic    start_o,
  output blk_op_e op_o,
  output logic    busy_n_o,
  output logic    done_o
);
  localparam int CNT_W = $clog2(CLR_CYCLES + 1);

  logic             active_q, start_q;
  blk_op_e          op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             go;

  assign go     = !active_q && head_ready_i && (head_op_i != OP_LOAD || head_dok_i);
  assign done_o = active_q && ((op_q == OP_LOAD) ? wr_done_i : (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      start_q  <= 1'b0;
      op_q     <= OP_LOAD;
      cnt_q    <= '0;
    end else begin
      start_q <= go;
      if (go) begin
        active_q <= 1'b1;
        op_q     <= head_op_i;
        cnt_q    <= CNT_W'(CLR_CYCLES - 1);
      end else if (active_q) begin
        if (done_o) active_q <= 1'b0;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign start_o  = start_q;
  assign op_o     = op_q;
  assign busy_n_o = !active_q;

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R2
  start_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_n_o && $past(busy_n_o));
  // R3
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_n_o) |-> $past(wr_done_i) || $past(op_q != OP_LOAD));
endmodule

// File: rtl/blk_load_sched.sv
module blk_load_sched
  import blk_sched_pkg::*;
#(
  parameter int CLR_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cw_valid_i,
  input  logic [1:0] cw_op_i,
  input  logic       data_done_i,
  input  logic       load_req_i,
  input  logic       wr_done_i,
  output logic       wr_start_o,
  output logic [1:0] wr_op_o,
  output logic       wr_buf_o,
  output logic       busy_n_o,
  output logic       req_ovr_o,
  output logic       buf_ovr_o
);
  localparam int NUM_BUF = 2;

  slot_st_e st  [NUM_BUF];
  blk_op_e  sop [NUM_BUF];
  logic     dok [NUM_BUF];

  logic    rx_q, hd_q, last_q, req_ovr_q, buf_ovr_q;
  logic    cw_take, req_take, data_take, done;
  blk_op_e run_op;

  assign cw_take   = cw_valid_i && (st[rx_q] == SLOT_EMPTY);
  assign req_take  = load_req_i && (st[rx_q] == SLOT_OPEN);
  assign data_take = data_done_i && (st[last_q] != SLOT_EMPTY);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    blk_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .open_i  (cw_take && rx_q == 1'(i)),
      .op_i    (blk_op_e'(cw_op_i)),
      .close_i (req_take && rx_q == 1'(i)),
      .data_i  (data_take && last_q == 1'(i)),
      .free_i  (done && hd_q == 1'(i)),
      .state_o (st[i]),
      .op_o    (sop[i]),
      .dok_o   (dok[i])
    );
  end

  blk_drain_seq #(.CLR_CYCLES(CLR_CYCLES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_ready_i (st[hd_q] == SLOT_READY),
    .head_op_i    (sop[hd_q]),
    .head_dok_i   (dok[hd_q]),
    .wr_done_i    (wr_done_i),
    .start_o      (wr_start_o),
    .op_o         (run_op),
    .busy_n_o     (busy_n_o),
    .done_o       (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= 1'b0;
      hd_q      <= 1'b0;
      last_q    <= 1'b0;
      req_ovr_q <= 1'b0;
      buf_ovr_q <= 1'b0;
    end else begin
      if (cw_take) last_q <= rx_q;
      if (req_take) rx_q <= ~rx_q;
      if (done) hd_q <= ~hd_q;
      if (load_req_i && !req_take) req_ovr_q <= 1'b1;
      if (cw_valid_i && !cw_take) buf_ovr_q <= 1'b1;
    end
  end

  assign wr_op_o   = run_op;
  assign wr_buf_o  = hd_q;
  assign req_ovr_o = req_ovr_q;
  assign buf_ovr_o = buf_ovr_q;

  // R8
  req_ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ovr_o |=> req_ovr_o);
  // R9
  buf_ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_ovr_o |=> buf_ovr_o);
  // R7
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_n_o && $past(!busy_n_o) |-> $stable(wr_buf_o));
endmodule

// File: tb/blk_load_sched_tb_top.sv
module blk_load_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLR_N = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cw_valid_i = 0, data_done_i = 0, load_req_i = 0, wr_done_i = 0;
  logic [1:0] cw_op_i = 2'b00;
  logic wr_start_o, wr_buf_o, busy_n_o, req_ovr_o, buf_ovr_o;
  logic [1:0] wr_op_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [2:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  blk_load_sched #(.CLR_CYCLES(CLR_N)) dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop expected (op, buf) on each start
  always @(negedge clk_i) begin
    if (rst_ni && wr_start_o) begin
      if (exp_q.size() == 0) chk("R8 unexpected start", 1, 0);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        chk("R2 wr_op", int'(wr_op_o), int'(e[2:1]));
        chk("R7 wr_buf", int'(wr_buf_o), int'(e[0]));
        chk("R2 busy low at start", int'(busy_n_o), 0);
      end
    end
  end

  task automatic expect_start(input logic [1:0] op, input logic b);
    exp_q.push_back({op, b});
  endtask

  task automatic send_cw(input logic [1:0] op);
    @(negedge clk_i); cw_valid_i = 1; cw_op_i = op;
    @(negedge clk_i); cw_valid_i = 0;
  endtask
  task automatic send_data();
    @(negedge clk_i); data_done_i = 1;
    @(negedge clk_i); data_done_i = 0;
  endtask
  task automatic send_req();
    @(negedge clk_i); load_req_i = 1;
    @(negedge clk_i); load_req_i = 0;
  endtask
  task automatic send_wdone();
    @(negedge clk_i); wr_done_i = 1;
    @(negedge clk_i); wr_done_i = 0;
  endtask

  task automatic count_busy(input string tag);
    int cnt = 0;
    while (!busy_n_o && cnt < 50) begin
      cnt++;
      @(negedge clk_i);
      wr_done_i = 0;
    end
    chk(tag, cnt, CLR_N);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 busy_n", int'(busy_n_o), 1);
    chk("R1 start", int'(wr_start_o), 0);
    chk("R1 req_ovr", int'(req_ovr_o), 0);
    chk("R1 buf_ovr", int'(buf_ovr_o), 0);

    // R2 R3 data load, buffer 0
    expect_start(2'b00, 1'b0);
    send_cw(2'b00); send_data(); send_req();
    @(negedge clk_i);
    chk("R2 busy low after req", int'(busy_n_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R3 busy held until done", int'(busy_n_o), 0);
    send_wdone();
    chk("R3 busy high after done", int'(busy_n_o), 1);

    // R4 clear, buffer 1; writer done during clear is ignored (R3)
    expect_start(2'b01, 1'b1);
    send_cw(2'b01); send_req();
    @(negedge clk_i);
    wr_done_i = 1;
    count_busy("R4 clear busy length");

    // R3 done while idle has no effect
    send_wdone();
    repeat (2) @(negedge clk_i);
    chk("R3 idle done busy_n", int'(busy_n_o), 1);

    // R5 R8 R9 pending request and overruns
    expect_start(2'b00, 1'b0);
    expect_start(2'b10, 1'b1);
    send_cw(2'b00); send_data(); send_req();
    send_cw(2'b10); send_req();
    chk("R5 pending kept busy", int'(busy_n_o), 0);
    send_req();
    @(negedge clk_i);
    chk("R8 req_ovr set", int'(req_ovr_o), 1);
    send_cw(2'b01);
    @(negedge clk_i);
    chk("R9 buf_ovr set", int'(buf_ovr_o), 1);
    send_wdone();
    chk("R5 busy high one cycle", int'(busy_n_o), 1);
    @(negedge clk_i);
    chk("R5 pending started", int'(busy_n_o), 0);
    // R9 recovery: buffer 0 freed, new word accepted
    expect_start(2'b01, 1'b0);
    send_cw(2'b01); send_req();
    repeat (12) @(negedge clk_i);
    chk("R9 queue drained", exp_q.size(), 0);
    chk("R8 req_ovr sticky", int'(req_ovr_o), 1);
    chk("R9 buf_ovr sticky", int'(buf_ovr_o), 1);

    // R6 deferral until data complete
    expect_start(2'b00, 1'b1);
    send_cw(2'b00); send_req();
    repeat (4) @(negedge clk_i);
    chk("R6 held without data", int'(busy_n_o), 1);
    send_data();
    chk("R6 not yet started", int'(busy_n_o), 1);
    @(negedge clk_i);
    chk("R6 started after data", int'(busy_n_o), 0);
    send_wdone();

    // R10 fill code is timed
    expect_start(2'b11, 1'b0);
    send_cw(2'b11); send_req();
    @(negedge clk_i);
    count_busy("R10 fill busy length");
    repeat (3) @(negedge clk_i);
    chk("R7 all starts seen", exp_q.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule